// File: doc/BRIEF.md
# Compare-Match Interval Timer Channel

This block is one timer channel with a counter of `CNT_W` bits (32 by default), programmed through a simple read/write register port. Software sets the compare value, picks a mode in the control register, and then writes the start trigger. To halt the channel it writes the stop trigger, then reads the enable status until it shows 0.

There are two modes. In interval mode the counter is loaded from the compare register and counts down. When it reaches zero, the channel raises the interrupt and reloads. A compare value of N-1 therefore gives one interrupt every N clocks. In free-running mode the counter is cleared on start and counts up through its full range, wrapping to zero. Each time it equals the compare value, the interrupt pulses once. Software can use that pulse as a one-shot event, or ignore it and use the counter as a time base.

The register port carries no streaming data, so it stays a plain strobe interface with no back-pressure. A write completes on the clock edge where `wr_en` is high. A read returns its data on `rdata` in the cycle after the edge where `rd_en` is high.

Top module: `tmr_channel`

## Requirements
- R1: After reset the channel is stopped, `irq` is low, and compare (offset 0x00), counter (0x04), status (0x10) and control (0x20) all read 0.
- R2: Writing a value with bit 0 set to offset 0x14 starts the channel, and status bit 0 reads 1 from the next cycle. Writing bit 0 set to offset 0x18 stops it, and status bit 0 reads 0 from the next cycle. A trigger write with bit 0 clear has no effect.
- R3: In interval mode (control bit 1 = 0), start loads the counter with the compare value C. The counter then counts down. The first `irq` comes C+1 cycles after the start edge, and later ones every C+1 cycles.
- R4: In free-running mode (control bit 1 = 1), start clears the counter to 0. The counter then increments by 1 every cycle, so back-to-back reads of offset 0x04 right after start return 0 and then 1.
- R5: In free-running mode `irq` is high for exactly one cycle, in the cycle after the counter equals the compare value. With compare M, the first pulse comes M+1 cycles after the start edge.
- R6: In free-running mode the counter wraps from all ones to 0, so the next match comes 2^CNT_W cycles after the previous one.
- R7: Writes to compare or control while the channel is running are ignored.
- R8: While the channel is stopped, the counter holds its value and `irq` stays low.
- R9: Control keeps only bit 1 (the mode bit). A read of offset 0x20 returns that bit in position 1 and 0 in every other bit.
- R10: Read data is registered and appears one cycle after `rd_en`. Reads of the trigger offsets, and of any offset not listed, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
A trigger takes effect on the write edge, so status reflects it from the next read onward. Read data appears one cycle after its `rd_en` edge and shows the counter value from before that edge. That makes the first counter read after a start return the loaded value, 0 or the compare value. The interrupt is registered. It comes C+1 cycles after the start edge in interval mode, and M+1 cycles after start in free-running mode, then every 2^CNT_W cycles. The bench drives inputs and samples outputs on falling edges, and counts falling edges from the start to the first `irq`. The bench builds the channel with a 12-bit counter so that the wrap can be observed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_CMP   = 'h00;
  localparam int unsigned OFF_CNT   = 'h04;
  localparam int unsigned OFF_STAT  = 'h10;
  localparam int unsigned OFF_START = 'h14;
  localparam int unsigned OFF_STOP  = 'h18;
  localparam int unsigned OFF_CTL   = 'h20;

  localparam int unsigned MODE_BIT  = 1;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_FREERUN  = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              running,
  output logic [CNT_W-1:0]  cmp,
  output tmr_mode_e         mode,
  output logic              start_req,
  output logic              stop_req
);
  logic hit_cmp, hit_ctl;

  assign hit_cmp   = wr_en && (addr == ADDR_W'(OFF_CMP));
  assign hit_ctl   = wr_en && (addr == ADDR_W'(OFF_CTL));
  assign start_req = wr_en && (addr == ADDR_W'(OFF_START)) && wdata[0];
  assign stop_req  = wr_en && (addr == ADDR_W'(OFF_STOP)) && wdata[0];

  // configuration is frozen while the channel runs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp  <= '0;
      mode <= MODE_INTERVAL;
    end else if (!running) begin
      if (hit_cmp) cmp  <= wdata[CNT_W-1:0];
      if (hit_ctl) mode <= tmr_mode_e'(wdata[MODE_BIT]);
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] cmp,
  output logic             running,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  logic cnt_zero, cnt_match;

  assign cnt_zero  = (cnt == '0);
  assign cnt_match = (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      irq     <= 1'b0;
    end else if (start_req && !running) begin
      running <= 1'b1;
      cnt     <= (mode == MODE_FREERUN) ? '0 : cmp;
      irq     <= 1'b0;
    end else if (stop_req) begin
      running <= 1'b0;
      irq     <= 1'b0;
    end else if (running) begin
      if (mode == MODE_FREERUN) begin
        cnt <= cnt + 1'b1;
        irq <= cnt_match;
      end else if (cnt_zero) begin
        cnt <= cmp;
        irq <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
        irq <= 1'b0;
      end
    end else begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cmp,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              running,
  input  tmr_mode_e         mode,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(OFF_CMP))       rd_d = DATA_W'(cmp);
    else if (addr == ADDR_W'(OFF_CNT))  rd_d = DATA_W'(cnt);
    else if (addr == ADDR_W'(OFF_STAT)) rd_d[0] = running;
    else if (addr == ADDR_W'(OFF_CTL))  rd_d[MODE_BIT] = (mode == MODE_FREERUN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [CNT_W-1:0] cmp_w, cnt_w;
  logic             run_w, start_w, stop_w;
  tmr_mode_e        mode_w;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .running(run_w), .cmp(cmp_w), .mode(mode_w),
    .start_req(start_w), .stop_req(stop_w)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start_req(start_w), .stop_req(stop_w),
    .mode(mode_w), .cmp(cmp_w), .running(run_w), .cnt(cnt_w), .irq(irq)
  );

  tmr_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .cmp(cmp_w),
    .cnt(cnt_w), .running(run_w), .mode(mode_w), .rdata(rdata)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic              run,
  input logic              fr_mode,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp
);
  logic wr_start, wr_stop;
  assign wr_start = wr_en && (addr == ADDR_W'(OFF_START)) && wdata[0];
  assign wr_stop  = wr_en && (addr == ADDR_W'(OFF_STOP)) && wdata[0];

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> run);
  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stop |=> !run);
  p_fr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fr_mode) |=> (!run || cnt == CNT_W'($past(cnt) + 1'b1)));
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && fr_mode) |=> !irq);
  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(cmp));
  p_no_irq_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_start) |=> $stable(cnt));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .run(run_w), .fr_mode(mode_w == tmr_pkg::MODE_FREERUN),
  .cnt(cnt_w), .cmp(cmp_w)
);

// File: tb/tmr_channel_tb_top.sv
module tmr_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // all tasks begin and end just after a falling edge
  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] d);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_irq(input int lim, output int k);
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (irq) begin k = i; break; end
    end
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    check("R1", "irq", irq, 0);
    rd('h00, d); check("R1", "cmp", d, 0);
    rd('h04, d); check("R1", "cnt", d, 0);
    rd('h10, d); check("R1", "status", d, 0);
    rd('h20, d); check("R1", "ctl", d, 0);
  endtask

  task automatic t_ctl_and_map();
    logic [DATA_W-1:0] d;
    wr('h20, 'hFF); rd('h20, d); check("R9", "ctl keeps bit1 only", d, 'h2);
    wr('h20, 'h00); rd('h20, d); check("R9", "ctl cleared", d, 'h0);
    rd('h08, d); check("R10", "unmapped read", d, 0);
    rd('h14, d); check("R10", "start offset read", d, 0);
    wr('h14, 'h0); rd('h10, d); check("R2", "start with bit0 clear", d, 0);
  endtask

  task automatic t_interval();
    logic [DATA_W-1:0] d;
    int k, pulses;
    wr('h00, 9); wr('h20, 0); wr('h14, 1);
    wait_irq(40, k); check("R3", "first interval irq", k, 10);
    wait_irq(40, k); check("R3", "second interval irq", k, 10);
    pulses = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (irq) pulses++; end
    check("R3", "pulses in 50 cycles", pulses, 5);
    rd('h10, d); check("R2", "status running", d, 1);
  endtask

  task automatic t_stop_hold();
    logic [DATA_W-1:0] d, e;
    int pulses;
    wr('h18, 1);
    rd('h10, d); check("R2", "status after stop", d, 0);
    rd('h04, d); rd('h04, e); check("R8", "counter held", e, d);
    pulses = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (irq) pulses++; end
    check("R8", "no irq while stopped", pulses, 0);
  endtask

  task automatic t_locked();
    logic [DATA_W-1:0] d;
    wr('h14, 1);
    rd('h04, d); check("R3", "start loads compare", d, 9);
    wr('h00, 'h55); wr('h20, 'h2);
    rd('h00, d); check("R7", "cmp write ignored", d, 9);
    rd('h20, d); check("R7", "ctl write ignored", d, 0);
    wr('h18, 1);
  endtask

  task automatic t_freerun_count();
    logic [DATA_W-1:0] d;
    wr('h00, 0); wr('h20, 'h2); wr('h14, 1);
    rd('h04, d); check("R4", "counter cleared on start", d, 0);
    rd('h04, d); check("R4", "counter increments", d, 1);
    wr('h18, 1);
  endtask

  task automatic t_freerun_irq();
    int k;
    wr('h00, 5); wr('h14, 1);
    wait_irq(40, k); check("R5", "first match irq", k, 6);
    wait_irq((1 << CNT_W) + 20, k); check("R6", "match after wrap", k, 1 << CNT_W);
    @(negedge clk); check("R5", "irq single cycle", irq, 0);
    wr('h18, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl_and_map();
    t_interval();
    t_stop_hold();
    t_locked();
    t_freerun_count();
    t_freerun_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule